// File: doc/BRIEF.md
# Domain-Sequential Access Checker

This block sits on the path from bus initiators to a shared target and returns a permit or deny verdict for every transaction. Each request carries a requester identifier, an address and an access kind. The block reads the requester's row in a requester table to learn which memory domains it may use. It then walks those domains one per cycle, lowest index first. In each cycle it compares the address and access kind against every entry of the current domain at the same time. It grants on the first domain that holds a matching entry with the right permission. It faults when no allowed domain is left.

A trusted controller loads three tables through a simple write port: the per-entry address ranges and permissions, the domain grouping, and the requester masks. A lock input freezes all three until reset. Requests use a valid/ready handshake, and only one request is in flight at a time. The verdict costs two cycles of overhead plus one cycle for each domain examined.

Top module: `domain_scan_guard`

## Requirements
- R1: During and right after reset, req_ready is 1 and both res_grant and res_fault are 0. All table contents reset to zero, so every requester has no allowed domain.
- R2: A request is accepted in a cycle where req_valid and req_ready are both 1. req_ready then stays 0 until the cycle in which that request's verdict is shown, and it is 1 again in that cycle.
- R3: Bit d of a requester's mask allows domain d. Only entries of allowed domains take part in the check.
- R4: Domain d holds the entries with index from S to E-1. E is the stored end value of domain d. S is 0 for domain 0 and the end value of domain d-1 otherwise. Domains whose S is not below E are empty and never match.
- R5: An entry matches when its low bound <= address <= its high bound, both inclusive, and its permission bit for the access kind is set. The kinds are 0 = read (permission bit 0), 1 = write (bit 1) and 2 = execute (bit 2). Kind 3 is never permitted.
- R6: Allowed domains are examined in ascending index order. The first one that contains a matching entry grants. If the request is accepted in cycle c and that domain is the k-th allowed domain examined, res_grant is 1 in cycle c+2+k.
- R7: When none of the n allowed domains matches, res_fault is 1 in cycle c+2+n. With no allowed domain at all, it is 1 in cycle c+2.
- R8: Each accepted request produces exactly one verdict. Either res_grant or res_fault is 1, never both, and only for a single cycle.
- R9: A write with cfg_we=1 selects its table with cfg_sel and its row with cfg_idx. The tables are 0 = entry low bound (cfg_wdata), 1 = entry high bound, 2 = entry permission (cfg_wdata[2:0]), 3 = domain end (cfg_wdata[4:0]) and 4 = requester mask (cfg_wdata[7:0]). Rows beyond a table's depth are ignored.
- R10: A 1 on cfg_lock sets a lock that holds until reset. From the next cycle on, all configuration writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_rid | input | 4 | Requester identifier |
| req_addr | input | 32 | Transaction address |
| req_type | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| res_grant | output | 1 | One-cycle permit verdict |
| res_fault | output | 1 | One-cycle deny verdict |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Table select |
| cfg_idx | input | 8 | Row within the selected table |
| cfg_wdata | input | 32 | Write data |
| cfg_lock | input | 1 | Freeze the tables until reset |

## Verification
A verdict is due exactly 2+k cycles after the acceptance cycle. Here k counts the allowed domains examined up to the granting one, or all of them for a fault. For a requester with no domains, k is 0. The bench samples on the falling edge and notes the cycle number at the edge where the request is taken. It queues the predicted verdict together with its due cycle. A monitor pops the entry when a verdict appears and compares both kind and cycle. An item that reaches its due cycle with no verdict fails as overdue. In every cycle between acceptance and verdict, req_ready must read 0.

// File: rtl/domain_scan_guard.sv
module domain_scan_guard #(
  parameter int NUM_DOM = 8,
  parameter int NUM_ENT = 16,
  parameter int NUM_RID = 16,
  parameter int AW = 32,
  parameter int CIW = 8,
  localparam int RW = (NUM_RID > 1) ? $clog2(NUM_RID) : 1,
  localparam int DW = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  localparam int EW = $clog2(NUM_ENT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [RW-1:0]  req_rid,
  input  logic [AW-1:0]  req_addr,
  input  logic [1:0]     req_type,
  output logic           res_grant,
  output logic           res_fault,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_sel,
  input  logic [CIW-1:0] cfg_idx,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           cfg_lock
);

  typedef enum logic [1:0] {IDLE, LOOK, SCAN} st_t;
  st_t st;

  logic               locked;
  logic [AW-1:0]      ent_lo   [NUM_ENT];
  logic [AW-1:0]      ent_hi   [NUM_ENT];
  logic [2:0]         ent_perm [NUM_ENT];
  logic [EW-1:0]      dom_end  [NUM_DOM];
  logic [NUM_DOM-1:0] rid_mask [NUM_RID];

  logic [RW-1:0]      rid_q;
  logic [AW-1:0]      addr_q;
  logic [1:0]         type_q;
  logic [NUM_DOM-1:0] pend, rest;
  logic [DW-1:0]      cur;
  logic [EW-1:0]      lo_idx, hi_idx;
  logic [NUM_ENT-1:0] hit_vec;
  logic [2:0]         need;

  assign req_ready = (st == IDLE);
  // kind 3 shifts the bit out, leaving no permission that can match
  assign need = 3'b001 << type_q;

  always_comb begin
    cur = '0;
    for (int d = NUM_DOM - 1; d >= 0; d--)
      if (pend[d]) cur = DW'(d);
  end

  assign hi_idx = dom_end[cur];
  assign lo_idx = (cur == '0) ? '0 : dom_end[cur - DW'(1)];
  assign rest   = pend & ~(NUM_DOM'(1) << cur);

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign hit_vec[e] = (EW'(e) >= lo_idx) && (EW'(e) < hi_idx) &&
                        (addr_q >= ent_lo[e]) && (addr_q <= ent_hi[e]) &&
                        (|(ent_perm[e] & need));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      rid_q     <= '0;
      addr_q    <= '0;
      type_q    <= '0;
      pend      <= '0;
      res_grant <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_grant <= 1'b0;
      res_fault <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          rid_q  <= req_rid;
          addr_q <= req_addr;
          type_q <= req_type;
          st     <= LOOK;
        end
        LOOK: begin
          pend <= rid_mask[rid_q];
          if (rid_mask[rid_q] == '0) begin
            res_fault <= 1'b1;
            st        <= IDLE;
          end else begin
            st <= SCAN;
          end
        end
        SCAN: begin
          if (|hit_vec) begin
            res_grant <= 1'b1;
            st        <= IDLE;
          end else begin
            pend <= rest;
            if (rest == '0) begin
              res_fault <= 1'b1;
              st        <= IDLE;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      for (int e = 0; e < NUM_ENT; e++) begin
        ent_lo[e]   <= '0;
        ent_hi[e]   <= '0;
        ent_perm[e] <= '0;
      end
      for (int d = 0; d < NUM_DOM; d++) dom_end[d] <= '0;
      for (int r = 0; r < NUM_RID; r++) rid_mask[r] <= '0;
    end else begin
      if (cfg_lock) locked <= 1'b1;
      if (cfg_we && !locked) begin
        for (int e = 0; e < NUM_ENT; e++)
          if (cfg_idx == CIW'(e)) begin
            if (cfg_sel == 3'd0) ent_lo[e]   <= cfg_wdata;
            if (cfg_sel == 3'd1) ent_hi[e]   <= cfg_wdata;
            if (cfg_sel == 3'd2) ent_perm[e] <= cfg_wdata[2:0];
          end
        for (int d = 0; d < NUM_DOM; d++)
          if (cfg_idx == CIW'(d) && cfg_sel == 3'd3) dom_end[d] <= cfg_wdata[EW-1:0];
        for (int r = 0; r < NUM_RID; r++)
          if (cfg_idx == CIW'(r) && cfg_sel == 3'd4) rid_mask[r] <= cfg_wdata[NUM_DOM-1:0];
      end
    end
  end

endmodule

module domain_scan_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic res_grant,
  input logic res_fault,
  input logic locked
);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_grant && res_fault));
  a_r8_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_grant |=> !res_grant);
  a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |=> !res_fault);
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r2_verdict_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (res_grant || res_fault) |-> $past(!req_ready));
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

bind domain_scan_guard domain_scan_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_grant(res_grant), .res_fault(res_fault), .locked(locked)
);

// File: tb/domain_scan_guard_tb.sv
module domain_scan_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_rid = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_type = '0;
  logic        res_grant, res_fault;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_lock = 1'b0;

  domain_scan_guard u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rid(req_rid), .req_addr(req_addr), .req_type(req_type),
    .res_grant(res_grant), .res_fault(res_fault), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_lock(cfg_lock)
  );

  always #2 clk = ~clk;

  typedef struct { bit grant; int due; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_lo[16], m_hi[16];
  logic [2:0]  m_perm[16];
  int          m_end[8];
  logic [7:0]  m_mask[16];
  bit          m_locked = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wcfg(input int sel, input int idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_idx = 8'(idx); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!m_locked) begin
      if (sel == 0 && idx < 16) m_lo[idx] = data;
      if (sel == 1 && idx < 16) m_hi[idx] = data;
      if (sel == 2 && idx < 16) m_perm[idx] = data[2:0];
      if (sel == 3 && idx < 8)  m_end[idx] = int'(data[4:0]);
      if (sel == 4 && idx < 16) m_mask[idx] = data[7:0];
    end
  endtask

  task automatic entry(input int idx, input logic [31:0] lo, input logic [31:0] hi, input int perm);
    wcfg(0, idx, lo); wcfg(1, idx, hi); wcfg(2, idx, 32'(perm));
  endtask

  function automatic void predict(input int rid, input logic [31:0] addr, input int kind,
                                  output bit g, output int k);
    logic [2:0] need;
    int start;
    need = (kind == 3) ? 3'b000 : 3'(1 << kind);
    g = 1'b0; k = 0; start = 0;
    for (int d = 0; d < 8; d++) begin
      if (m_mask[rid][d] && !g) begin
        k++;
        for (int e = start; e < m_end[d]; e++)
          if (addr >= m_lo[e] && addr <= m_hi[e] && (m_perm[e] & need) != 0) g = 1'b1;
      end
      start = m_end[d];
    end
  endfunction

  task automatic send(input int rid, input logic [31:0] addr, input int kind, input string tag);
    bit g; int k, c;
    exp_t it;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1; req_rid = 4'(rid); req_addr = addr; req_type = 2'(kind);
    c = cyc;
    predict(rid, addr, kind, g, k);
    @(posedge clk); #1;
    it.grant = g; it.due = c + 2 + k; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && !done) begin
      if (res_grant || res_fault) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8", "verdict with nothing pending", 1, 0);
        end else begin
          e = q.pop_front();
          chk(!(res_grant && res_fault), "R8", "both verdicts", 1, 0);
          chk(res_grant == e.grant, e.tag, "grant bit", int'(res_grant), int'(e.grant));
          chk(cyc == e.due, e.tag, "verdict cycle", cyc, e.due);
          chk(req_ready == 1'b1, "R2", "ready in verdict cycle", int'(req_ready), 1);
        end
      end else if (q.size() > 0) begin
        if (cyc >= q[0].due) begin
          e = q.pop_front();
          chk(1'b0, e.tag, "verdict overdue at cycle", cyc, e.due);
        end else begin
          chk(req_ready == 1'b0, "R2", "ready while busy", int'(req_ready), 0);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_perm[i] = 0; m_mask[i] = 0; end
    for (int i = 0; i < 8; i++) m_end[i] = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && !res_grant && !res_fault, "R1", "outputs in reset", int'({req_ready, res_grant, res_fault}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !res_grant && !res_fault, "R1", "outputs after reset", int'({req_ready, res_grant, res_fault}), 4);
    send(0, 32'h1000, 0, "R1");

    // R9: load entries, grouping and masks
    entry(0, 32'h1000, 32'h1FFF, 1);
    entry(1, 32'h2000, 32'h2FFF, 3);
    entry(2, 32'h3000, 32'h30FF, 4);
    entry(3, 32'h1000, 32'h1FFF, 2);
    entry(4, 32'h4000, 32'h4000, 7);
    entry(5, 32'h8000, 32'h8FFF, 1);
    entry(6, 32'h2000, 32'h2FFF, 4);
    entry(7, 32'h0, 32'hFFFF_FFFF, 0);
    wcfg(3, 0, 2); wcfg(3, 1, 5); wcfg(3, 2, 5); wcfg(3, 3, 8);
    for (int d = 4; d < 8; d++) wcfg(3, d, 8);
    wcfg(4, 0, 32'h01); wcfg(4, 1, 32'h0B); wcfg(4, 2, 32'h00);
    wcfg(4, 3, 32'hFF); wcfg(4, 4, 32'h84);
    wcfg(4, 20, 32'hFF);

    send(0, 32'h1000, 0, "R5");
    send(0, 32'h1FFF, 0, "R5");
    send(0, 32'h0FFF, 0, "R5");
    send(0, 32'h2000, 0, "R3");
    send(0, 32'h1500, 1, "R7");
    send(1, 32'h1500, 1, "R6");
    send(1, 32'h4000, 0, "R4");
    send(1, 32'h8000, 0, "R6");
    send(1, 32'h2800, 2, "R6");
    send(1, 32'h9000, 0, "R7");
    send(1, 32'h4000, 3, "R5");
    send(2, 32'h1000, 0, "R7");
    send(3, 32'h8000, 0, "R4");
    send(3, 32'hFFFF_0000, 0, "R7");
    send(4, 32'h1000, 0, "R4");
    send(5, 32'h1000, 0, "R9");

    wcfg(4, 2, 32'h08);
    send(2, 32'h8000, 0, "R9");

    @(negedge clk); cfg_lock = 1'b1;
    @(negedge clk); cfg_lock = 1'b0;
    m_locked = 1'b1;
    wcfg(4, 2, 32'h01);
    wcfg(2, 0, 32'h0);
    send(2, 32'h8000, 0, "R10");
    send(2, 32'h1000, 0, "R10");
    send(0, 32'h1000, 0, "R10");

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R8", "verdicts left pending", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule